// File: doc/BRIEF.md
# Interruptible Accumulator Processor

A compact 16-bit processor built around one accumulator register. It runs its program from a single-port synchronous word memory outside the block. Every instruction word splits into a 4-bit operation code in bits [15:12] and a 12-bit direct word address in bits [11:0]. Data words are sign-magnitude: bit 15 is the sign (1 = negative) and bits [14:0] are the magnitude. The supported operations are loading the accumulator, storing it, and adding a memory word into it with sign-magnitude rules.

Each instruction runs in phases: a two-cycle fetch, an execute cycle, an optional operand-read cycle, and then an interrupt check. If the request line is high during the check and interrupts are enabled, the address of the next instruction goes into a dedicated return register. Interrupts are then masked and execution continues at a fixed handler address. A return instruction resumes the interrupted program and unmasks interrupts. Requests that arrive while the handler runs stay pending until it returns.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter is 0: the first memory access after reset is a read of address 0. `halted`, `ovf` and `mem_we` are low while reset is held.
- R2: Instructions are fetched from consecutive addresses. The operation code is bits [15:12] and the operand address is bits [11:0]. A load or add takes 5 cycles, a store 4 cycles, and a halt reaches the halted state 3 cycles after its fetch starts.
- R3: Code 4'b0001 loads the accumulator from the operand address. Code 4'b0010 writes the accumulator to the operand address. A read and a write are never requested in the same cycle.
- R4: Code 4'b0101 adds the memory word into the accumulator. When the signs are equal, the magnitudes are summed and the sign is kept.
- R5: When the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. A zero result always has sign 0.
- R6: A magnitude carry out of bit 14 sets the sticky `ovf` output, which stays high until reset. In the default configuration the result keeps the low 15 bits of the magnitude.
- R7: In the interrupt check after an instruction, a high `irq` with interrupts enabled makes the next fetch read address 12'hF00. The address of the next instruction is saved and interrupts are masked.
- R8: While interrupts are masked, `irq` is not taken and the saved address is unchanged. A request still high after the return is taken in the check right after the return.
- R9: Code 4'b1111 reloads the program counter from the saved address and unmasks interrupts.
- R10: Code 4'b0000 halts: `halted` stays high and no memory read or write follows, even with `irq` high.
- R11: Any other operation code changes neither the accumulator nor memory and moves on to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Word address for memory |
| mem_re | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, one cycle after `mem_re` |
| halted | output | 1 | Processor has stopped |
| ovf | output | 1 | Sticky magnitude overflow |

## Verification
A wrong opcode decode or wrong program counter shows up at the memory port in the very next access: an unexpected read address in the logged read sequence, or a write to the wrong place. A wrong accumulator or sign rule is exposed by the store that follows, whose data the bench compares with values worked out from the sign-magnitude rules. Errors in the interrupt state, such as a lost return address, an early unmask or a missed re-take, change the order of handler and main-program fetches within one instruction of the fault. Faults in the phase sequencing shift the cycle count to halt.

// File: rtl/acc_pkg.sv
package acc_pkg;
   typedef enum logic [2:0] {
      S_FREQ, S_FWAIT, S_EXEC, S_OPWAIT, S_CHK, S_HALT
   } state_t;

   typedef enum logic [3:0] {
      OP_HALT  = 4'h0,
      OP_LOAD  = 4'h1,
      OP_STORE = 4'h2,
      OP_ADD   = 4'h5,
      OP_RET   = 4'hF
   } opcode_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int unsigned DATA_W       = 16,
   parameter bit          OVF_SATURATE = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic              ovf
);
   localparam int unsigned MAG_W = DATA_W - 1;

   logic             a_s, b_s, same;
   logic [MAG_W-1:0] a_m, b_m, same_mag, diff_mag, res_mag;
   logic [MAG_W:0]   mag_sum;
   logic             a_ge, diff_sign, res_sign;

   always_comb begin
      a_s       = a[DATA_W-1];
      b_s       = b[DATA_W-1];
      a_m       = a[MAG_W-1:0];
      b_m       = b[MAG_W-1:0];
      same      = (a_s == b_s);
      mag_sum   = {1'b0, a_m} + {1'b0, b_m};
      a_ge      = (a_m >= b_m);
      diff_mag  = a_ge ? (a_m - b_m) : (b_m - a_m);
      diff_sign = a_ge ? a_s : b_s;
   end

   generate
      if (OVF_SATURATE) begin : g_sat
         assign same_mag = mag_sum[MAG_W] ? {MAG_W{1'b1}} : mag_sum[MAG_W-1:0];
      end else begin : g_wrap
         assign same_mag = mag_sum[MAG_W-1:0];
      end
   endgenerate

   always_comb begin
      res_mag  = same ? same_mag : diff_mag;
      res_sign = (res_mag == '0) ? 1'b0 : (same ? a_s : diff_sign);
      sum      = {res_sign, res_mag};
      ovf      = same & mag_sum[MAG_W];
   end
endmodule

// File: rtl/acc_dp.sv
module acc_dp #(
   parameter int unsigned DATA_W       = 16,
   parameter bit          OVF_SATURATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              add_en,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] acc,
   output logic              ovf
);
   logic [DATA_W-1:0] acc_q, sum_w;
   logic              ovf_q, ovf_w;

   acc_alu #(.DATA_W(DATA_W), .OVF_SATURATE(OVF_SATURATE)) u_alu (
      .a(acc_q), .b(opnd), .sum(sum_w), .ovf(ovf_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (ld_en)       acc_q <= opnd;
         else if (add_en) acc_q <= sum_w;
         if (add_en && ovf_w) ovf_q <= 1'b1;
      end
   end

   assign acc = acc_q;
   assign ovf = ovf_q;
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned HANDLER_ADDR = 'hF00,
   parameter int unsigned RESET_PC     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic              ld_en,
   output logic              add_en,
   output logic              halted,
   output state_t            st,
   output logic              ie,
   output logic [ADDR_W-1:0] save
);
   localparam int unsigned OP_W = DATA_W - ADDR_W;
   localparam logic [ADDR_W-1:0] HANDLER_PC = ADDR_W'(HANDLER_ADDR);
   localparam logic [ADDR_W-1:0] START_PC   = ADDR_W'(RESET_PC);

   state_t            st_q;
   logic [ADDR_W-1:0] pc_q, save_q;
   logic [DATA_W-1:0] ir_q;
   logic              ie_q;
   logic [OP_W-1:0]   op;
   logic [ADDR_W-1:0] field;
   logic              op_rd;

   always_comb begin
      op       = ir_q[DATA_W-1 -: OP_W];
      field    = ir_q[ADDR_W-1:0];
      op_rd    = (op == OP_LOAD) || (op == OP_ADD);
      mem_addr = (st_q == S_EXEC) ? field : pc_q;
      mem_re   = (st_q == S_FREQ) || ((st_q == S_EXEC) && op_rd);
      mem_we   = (st_q == S_EXEC) && (op == OP_STORE);
      ld_en    = (st_q == S_OPWAIT) && (op == OP_LOAD);
      add_en   = (st_q == S_OPWAIT) && (op == OP_ADD);
      halted   = (st_q == S_HALT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_FREQ;
         pc_q   <= START_PC;
         save_q <= '0;
         ir_q   <= '0;
         ie_q   <= 1'b1;
      end else begin
         case (st_q)
            S_FREQ:  st_q <= S_FWAIT;
            S_FWAIT: begin
               ir_q <= mem_rdata;
               pc_q <= pc_q + 1'b1;
               st_q <= S_EXEC;
            end
            S_EXEC: begin
               if (op_rd)               st_q <= S_OPWAIT;
               else if (op == OP_HALT)  st_q <= S_HALT;
               else begin
                  if (op == OP_RET) begin
                     pc_q <= save_q;
                     ie_q <= 1'b1;
                  end
                  st_q <= S_CHK;
               end
            end
            S_OPWAIT: st_q <= S_CHK;
            S_CHK: begin
               if (irq && ie_q) begin
                  save_q <= pc_q;
                  pc_q   <= HANDLER_PC;
                  ie_q   <= 1'b0;
               end
               st_q <= S_FREQ;
            end
            default: st_q <= S_HALT;
         endcase
      end
   end

   assign st   = st_q;
   assign ie   = ie_q;
   assign save = save_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned HANDLER_ADDR = 'hF00,
   parameter int unsigned RESET_PC     = 0,
   parameter bit          OVF_SATURATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic              ovf
);
   generate
      if (DATA_W != ADDR_W + 4) begin : g_bad_split
         $error("acc_cpu: DATA_W must equal ADDR_W plus a 4-bit opcode");
      end
      if (HANDLER_ADDR >= (1 << ADDR_W) || RESET_PC >= (1 << ADDR_W)) begin : g_bad_addr
         $error("acc_cpu: handler or reset address outside the address space");
      end
   endgenerate

   state_t            st_w;
   logic              ie_w, ld_w, add_w;
   logic [ADDR_W-1:0] save_w;
   logic [DATA_W-1:0] acc_w;

   acc_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .HANDLER_ADDR(HANDLER_ADDR), .RESET_PC(RESET_PC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .ld_en(ld_w), .add_en(add_w), .halted(halted),
      .st(st_w), .ie(ie_w), .save(save_w)
   );

   acc_dp #(.DATA_W(DATA_W), .OVF_SATURATE(OVF_SATURATE)) u_dp (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_w), .add_en(add_w),
      .opnd(mem_rdata), .acc(acc_w), .ovf(ovf)
   );

   assign mem_wdata = acc_w;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned HANDLER_ADDR = 'hF00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              mem_re,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              halted,
   input logic              ovf,
   input state_t            st,
   input logic              ie,
   input logic [ADDR_W-1:0] save
);
   // R3
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R7
   irq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CHK && irq && ie) |=> (mem_re && mem_addr == ADDR_W'(HANDLER_ADDR) && !ie));

   // R8
   save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CHK && !ie) |=> $stable(save));

   // R9
   unmask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ie) |-> $past(st == S_EXEC));

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_re && !mem_we));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .mem_re(mem_re), .mem_we(mem_we),
   .mem_addr(mem_addr), .halted(halted), .ovf(ovf),
   .st(st_w), .ie(ie_w), .save(save_w)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_re, mem_we, halted, ovf;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic [15:0] mem [4096];
   logic [11:0] rlog [64];
   int          rlog_n = 0;
   int          n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   acc_cpu u_acc_cpu (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .halted(halted), .ovf(ovf)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   always @(negedge clk)
      if (rst_n && mem_re && rlog_n < 64) begin
         rlog[rlog_n] = mem_addr;
         rlog_n = rlog_n + 1;
      end

   function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
      return {op, a};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = '0;
   endtask

   task automatic start();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rlog_n = 0;
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(input int drop_at, output int cyc);
      int seen = 0;
      cyc = 0;
      while (!halted && cyc < 1000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (mem_re && mem_addr == 12'hF00) begin
            seen++;
            if (drop_at > 0 && seen >= drop_at) irq = 1'b0;
         end
      end
   endtask

   task automatic check_log(input string tag, input logic [11:0] exp [], input int n);
      check({tag, " read count"}, rlog_n, n);
      for (int i = 0; i < n && i < rlog_n; i++) check({tag, " read addr"}, rlog[i], exp[i]);
   endtask

   task automatic t_reset();
      clear_mem();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 halted in reset", halted, 0);
      check("R1 ovf in reset", ovf, 0);
      check("R1 we in reset", mem_we, 0);
      rlog_n = 0;
      rst_n = 1'b1;
      #0.1;
      check("R1 first read", {mem_re, 4'h0, mem_addr}, {1'b1, 4'h0, 12'h000});
   endtask

   task automatic t_load_store();
      int cyc;
      logic [11:0] e [] = '{12'h000, 12'h100, 12'h001, 12'h002};
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h2, 12'h101);
      mem[2] = ins(4'h0, 12'h000);
      mem[12'h100] = 16'h1234;
      start();
      run_to_halt(0, cyc);
      check("R3 stored load value", mem[12'h101], 16'h1234);
      check("R2 cycles to halt", cyc, 12);
      check_log("R2", e, 4);
   endtask

   task automatic add_case(input string tag, input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] exp, input logic exp_ovf);
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h5, 12'h101);
      mem[2] = ins(4'h2, 12'h102);
      mem[3] = ins(4'h0, 12'h000);
      mem[12'h100] = a;
      mem[12'h101] = b;
      start();
      run_to_halt(0, cyc);
      check({tag, " sum"}, mem[12'h102], exp);
      check({tag, " ovf"}, ovf, exp_ovf);
   endtask

   task automatic t_add_same();
      add_case("R4 pos+pos", 16'h0005, 16'h0003, 16'h0008, 1'b0);
      add_case("R4 neg+neg", 16'h8005, 16'h8003, 16'h8008, 1'b0);
   endtask

   task automatic t_add_diff();
      add_case("R5 small pos + big neg", 16'h0003, 16'h8005, 16'h8002, 1'b0);
      add_case("R5 small neg + big pos", 16'h8003, 16'h0005, 16'h0002, 1'b0);
      add_case("R5 cancel to plus zero", 16'h0004, 16'h8004, 16'h0000, 1'b0);
   endtask

   task automatic t_ovf();
      int cyc;
      add_case("R6 wrap", 16'h7FFF, 16'h0003, 16'h0002, 1'b1);
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h5, 12'h100);
      mem[2] = ins(4'h5, 12'h101);
      mem[3] = ins(4'h2, 12'h102);
      mem[4] = ins(4'h0, 12'h000);
      mem[12'h100] = 16'h4000;
      mem[12'h101] = 16'h0001;
      start();
      run_to_halt(0, cyc);
      check("R6 wrapped then add", mem[12'h102], 16'h0001);
      check("R6 sticky after later add", ovf, 1);
   endtask

   task automatic t_nop();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h3, 12'h200);
      mem[2] = ins(4'h7, 12'h200);
      mem[3] = ins(4'h2, 12'h101);
      mem[4] = ins(4'h0, 12'h000);
      mem[12'h100] = 16'h0042;
      mem[12'h200] = 16'h0AAA;
      start();
      run_to_halt(0, cyc);
      check("R11 acc kept", mem[12'h101], 16'h0042);
      check("R11 memory kept", mem[12'h200], 16'h0AAA);
   endtask

   task automatic t_irq();
      int cyc;
      logic [11:0] e [] = '{12'h000, 12'h100, 12'hF00, 12'hF01, 12'h001, 12'h002};
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h2, 12'h101);
      mem[2] = ins(4'h0, 12'h000);
      mem[12'hF00] = ins(4'h2, 12'h120);
      mem[12'hF01] = ins(4'hF, 12'h000);
      mem[12'h100] = 16'h0007;
      irq = 1'b1;
      start();
      run_to_halt(1, cyc);
      check_log("R7 R9 handler entry and return", e, 6);
      check("R7 handler saw acc", mem[12'h120], 16'h0007);
      check("R9 main resumed", mem[12'h101], 16'h0007);
   endtask

   task automatic t_irq_masked();
      int cyc;
      logic [11:0] e [] = '{12'h000, 12'h100, 12'hF00, 12'hF01, 12'hF02,
                            12'hF00, 12'hF01, 12'hF02, 12'h001, 12'h002};
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h2, 12'h101);
      mem[2] = ins(4'h0, 12'h000);
      mem[12'hF00] = ins(4'h2, 12'h120);
      mem[12'hF01] = ins(4'h2, 12'h121);
      mem[12'hF02] = ins(4'hF, 12'h000);
      mem[12'h100] = 16'h0009;
      irq = 1'b1;
      start();
      run_to_halt(2, cyc);
      check_log("R8 masked then retaken", e, 10);
      check("R8 main store after retake", mem[12'h101], 16'h0009);
   endtask

   task automatic t_halt();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h0, 12'h000);
      irq = 1'b1;
      start();
      run_to_halt(0, cyc);
      repeat (20) @(negedge clk);
      check("R10 still halted", halted, 1);
      check("R10 no reads after halt", rlog_n, 1);
      irq = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_load_store();
      t_add_same();
      t_add_diff();
      t_ovf();
      t_nop();
      t_irq();
      t_irq_masked();
      t_halt();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule